// File: doc/BRIEF.md
# Multi-Channel Compare Event Unit

This block watches a free-running count produced elsewhere and raises a single-cycle event for each of its compare channels when the count steps onto the value held in that channel. The count source tells the block when the count has just moved up by one, and when a start or clear has just been applied. A match counts only when the count actually stepped. It does not count when the count was reset to zero or re-armed while it already equalled the compare value.

Software writes a compare value into a staging register. The value becomes active at the next step, start or clear edge. Because of this, a value two ahead of the current count is always caught, and a far-ahead value that has been replaced can never fire. Each channel drives an event pulse, gated by its own routing enable, and a sticky flag. Software clears the flag with a strobe. The flags, masked by interrupt enables, are ORed into one interrupt line. Channels from `IMPL_CH` upward are left out at elaboration.

Top module: `cmp_event_unit`

## Requirements
- R1: When `inc_i` is high (the count has just moved from `count_i`-1 to `count_i`, wrapping from all ones to 0) and the active value of an implemented channel equals `count_i`, that channel's bit of `evt_o` is high for exactly the following cycle.
- R2: A cycle with `clear_i` high never produces a compare event. In particular, an active value of 0 does not fire when the count is cleared to 0.
- R3: A cycle with `start_i` high never produces a compare event, even when the active value equals `count_i`.
- R4: If the count is N and a channel is written with N+2, that channel fires when the count steps to N+2.
- R5: A write on `wr_en_i` to channel `wr_ch_i` is staged. It becomes active at the first later clock edge with `inc_i`, `start_i` or `clear_i` high. Until then the old value is in use, so an old value of N+1 still fires on the step to N+1, and an old value above N+2 never fires.
- R6: An event reaches `evt_o` only if the channel's bit of `route_en_i` was high in the match cycle.
- R7: A match sets the channel's bit of `flag_o` from the next cycle, whatever the routing. The bit holds until a cycle with that bit of `flag_clr_i` high. `irq_o` is the OR of `flag_o & irq_en_i`.
- R8: Channels with index at or above `IMPL_CH` ignore writes and keep `evt_o` and `flag_o` at 0.
- R9: While `rst_n` is low, all active and staged values, `evt_o`, `flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Current count value |
| inc_i | input | 1 | Count has just stepped up by one |
| start_i | input | 1 | Start task applied this cycle |
| clear_i | input | 1 | Clear task applied this cycle (count now 0) |
| wr_en_i | input | 1 | Compare value write strobe |
| wr_ch_i | input | CH_W | Channel index for the write |
| wr_data_i | input | CNT_W | Compare value to stage |
| route_en_i | input | NUM_CH | Per-channel event routing enables |
| irq_en_i | input | NUM_CH | Per-channel interrupt enables |
| flag_clr_i | input | NUM_CH | Per-channel sticky flag clear strobes |
| evt_o | output | NUM_CH | Routed compare event pulses |
| flag_o | output | NUM_CH | Sticky compare flags |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume a well-behaved count source. It changes `count_i` only in a cycle that carries a step, start or clear strobe, it never raises `inc_i` on two cycles in a row with the same count, and it holds `count_i` steady otherwise. The stimulus follows these rules. Every step, start and clear is driven as a one-cycle strobe, together with a count value that the bench's own counter model has moved to match. Between strobes the inputs stay idle for at least a cycle, so each event pulse is observed alone.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  // A step that can match: a real increment not overlaid by a restart.
  function automatic logic qualified_step(input logic inc, input logic start,
                                          input logic clr);
    return inc & ~start & ~clr;
  endfunction

  // Edges on which a staged compare value becomes active.
  function automatic logic commit_edge(input logic inc, input logic start,
                                       input logic clr);
    return inc | start | clr;
  endfunction

  // Equality test kept here so the bench can state it independently.
  function automatic logic value_hit(input logic [63:0] cnt, input logic [63:0] val);
    return cnt == val;
  endfunction

endpackage

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int unsigned CNT_W = 24,
  parameter bit          IMPL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_ok_i,
  input  logic             boundary_i,
  input  logic             wr_hit_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             match_o
);
  import cmp_evt_pkg::*;

  generate
    if (IMPL) begin : g_live
      logic [CNT_W-1:0] active_q;
      logic [CNT_W-1:0] stage_q;
      logic             pend_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          active_q <= '0;
          stage_q  <= '0;
          pend_q   <= 1'b0;
        end else begin
          if (boundary_i) begin
            if (pend_q) active_q <= stage_q;
            pend_q <= wr_hit_i;
          end else if (wr_hit_i) begin
            pend_q <= 1'b1;
          end
          if (wr_hit_i) stage_q <= wr_data_i;
        end
      end

      assign match_o = step_ok_i &
                       value_hit(64'(count_i), 64'(active_q));
    end else begin : g_absent
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, count_i, step_ok_i, boundary_i,
                           wr_hit_i, wr_data_i};
      assign match_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cmp_flags.sv
module cmp_flags #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match_i,
  input  logic [NUM_CH-1:0] route_en_i,
  input  logic [NUM_CH-1:0] irq_en_i,
  input  logic [NUM_CH-1:0] flag_clr_i,
  output logic [NUM_CH-1:0] evt_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] evt_q;
  logic [NUM_CH-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      flag_q <= '0;
    end else begin
      evt_q  <= match_i & route_en_i;
      flag_q <= (flag_q & ~flag_clr_i) | match_i;
    end
  end

  assign evt_o  = evt_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & irq_en_i);

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned IMPL_CH = NUM_CH,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              inc_i,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] route_en_i,
  input  logic [NUM_CH-1:0] irq_en_i,
  input  logic [NUM_CH-1:0] flag_clr_i,
  output logic [NUM_CH-1:0] evt_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_o
);
  import cmp_evt_pkg::*;

  // Named internal events, visible to the checker.
  logic              step_ok;
  logic              boundary;
  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] match_vec;

  assign step_ok  = qualified_step(inc_i, start_i, clear_i);
  assign boundary = commit_edge(inc_i, start_i, clear_i);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign wr_hit[c] = wr_en_i && (wr_ch_i == CH_W'(c));

      cmp_channel #(
        .CNT_W (CNT_W),
        .IMPL  (c < IMPL_CH)
      ) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count_i),
        .step_ok_i  (step_ok),
        .boundary_i (boundary),
        .wr_hit_i   (wr_hit[c]),
        .wr_data_i  (wr_data_i),
        .match_o    (match_vec[c])
      );
    end
  endgenerate

  cmp_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match_vec),
    .route_en_i (route_en_i),
    .irq_en_i   (irq_en_i),
    .flag_clr_i (flag_clr_i),
    .evt_o      (evt_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/cmp_event_unit_chk.sv
module cmp_event_unit_chk #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned IMPL_CH = NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inc_i,
  input logic              start_i,
  input logic              clear_i,
  input logic [NUM_CH-1:0] route_en_i,
  input logic [NUM_CH-1:0] evt_o,
  input logic [NUM_CH-1:0] flag_o
);

  function automatic logic [NUM_CH-1:0] absent_mask();
    logic [NUM_CH-1:0] m;
    for (int i = 0; i < NUM_CH; i++) m[i] = (i >= IMPL_CH);
    return m;
  endfunction
  localparam logic [NUM_CH-1:0] ABSENT = absent_mask();

  AST_EVT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> $past(inc_i && !start_i && !clear_i)); // R1 R2 R3

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |=> ((evt_o & $past(evt_o)) == '0)); // R1

  AST_EVT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> ((evt_o & ~$past(route_en_i)) == '0)); // R6

  AST_FLAG_RISE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & ~$past(flag_o))) |-> $past(inc_i && !start_i && !clear_i)); // R7

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o | evt_o)) |-> (((flag_o | evt_o) & ABSENT) == '0)); // R8

endmodule

bind cmp_event_unit cmp_event_unit_chk #(
  .NUM_CH  (NUM_CH),
  .IMPL_CH (IMPL_CH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inc_i      (inc_i),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .route_en_i (route_en_i),
  .evt_o      (evt_o),
  .flag_o     (flag_o)
);

// File: tb/sim_cmp_event_unit.sv
module sim_cmp_event_unit;

  localparam int CW = 24;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          inc_i = 1'b0, start_i = 1'b0, clear_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_ch_i = '0;
  logic [CW-1:0] wr_data_i = '0;
  logic [NC-1:0] route_en_i = '1, irq_en_i = '0, flag_clr_i = '0;
  logic [NC-1:0] evt_o, flag_o;
  logic          irq_o;

  logic [CW-1:0] cnt = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_event_unit #(.CNT_W(CW), .NUM_CH(NC), .IMPL_CH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .inc_i(inc_i),
    .start_i(start_i), .clear_i(clear_i), .wr_en_i(wr_en_i),
    .wr_ch_i(wr_ch_i), .wr_data_i(wr_data_i), .route_en_i(route_en_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .evt_o(evt_o),
    .flag_o(flag_o), .irq_o(irq_o));

  typedef struct packed {
    logic [CW-1:0] cc;
    logic [CW-1:0] st;
    logic [7:0]    n;
    logic [1:0]    hits;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{cc: 24'd5,       st: 24'd0,       n: 8'd8,  hits: 2'd1},
    '{cc: 24'd5,       st: 24'd5,       n: 8'd3,  hits: 2'd0},
    '{cc: 24'd0,       st: 24'hFFFFFE,  n: 8'd3,  hits: 2'd1},
    '{cc: 24'd3,       st: 24'd4,       n: 8'd5,  hits: 2'd0},
    '{cc: 24'hFFFFFF,  st: 24'hFFFFF0,  n: 8'd16, hits: 2'd1},
    '{cc: 24'd10,      st: 24'd9,       n: 8'd1,  hits: 2'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk);
    cnt = cnt + 1'b1; count_i = cnt; inc_i = 1'b1;
    @(negedge clk);
    inc_i = 1'b0;
  endtask

  task automatic do_start(input logic [CW-1:0] v);
    @(negedge clk);
    cnt = v; count_i = cnt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    cnt = '0; count_i = cnt; clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] ch, input logic [CW-1:0] v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_ch_i = ch; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_fclr(input logic [NC-1:0] m);
    @(negedge clk);
    flag_clr_i = m;
    @(negedge clk);
    flag_clr_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(evt_o == '0, "R9 evt_o in reset", evt_o, 0);
    chk(flag_o == '0 && irq_o == 1'b0, "R9 flags/irq in reset", {flag_o, irq_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk on channel 0: R1 R2 R3 R5
    for (int r = 0; r < 6; r++) begin
      int hits;
      do_fclr('1);
      do_write(2'd0, ROWS[r].cc);
      do_start(ROWS[r].st);
      chk(evt_o[0] == 1'b0, "R3 no event on start", evt_o[0], 0);
      hits = 0;
      for (int s = 0; s < int'(ROWS[r].n); s++) begin
        do_step();
        if (evt_o[0]) hits++;
      end
      chk(hits == int'(ROWS[r].hits), "R1 table hit count", hits, ROWS[r].hits);
      chk(flag_o[0] == (ROWS[r].hits != 0), "R7 table flag", flag_o[0], ROWS[r].hits != 0);
    end

    // R2: value 0 at clear does not fire
    do_fclr('1);
    do_write(2'd1, 24'd0);
    do_start(24'd7);
    do_clear();
    chk(evt_o[1] == 1'b0, "R2 no event on clear to 0", evt_o[1], 0);
    do_step();
    chk(flag_o[1] == 1'b0, "R2 no flag after clear", flag_o[1], 0);

    // R4: write N+2 while count is N
    do_write(2'd2, 24'd100);
    do_start(24'd20);
    do_write(2'd2, 24'd22);
    do_step();
    chk(evt_o[2] == 1'b0, "R4 quiet at N+1", evt_o[2], 0);
    do_step();
    chk(evt_o[2] == 1'b1, "R4 fires at N+2", evt_o[2], 1);

    // R5: replaced old value above N+2 never fires
    do_fclr('1);
    do_write(2'd1, 24'd23);
    do_start(24'd20);
    do_write(2'd1, 24'd50);
    for (int s = 0; s < 3; s++) do_step();
    chk(flag_o[1] == 1'b0, "R5 old value above N+2 silent", flag_o[1], 0);

    // R5: old value N+1 still in use on next step, new value later
    do_write(2'd0, 24'd31);
    do_start(24'd30);
    do_write(2'd0, 24'd60);
    do_step();
    chk(evt_o[0] == 1'b1, "R5 old N+1 fires", evt_o[0], 1);
    do_start(24'd58);
    do_step();
    do_step();
    chk(evt_o[0] == 1'b1, "R5 new value active", evt_o[0], 1);

    // R6: routing off suppresses pulse, flag still set
    do_fclr('1);
    route_en_i = 4'b1110;
    do_write(2'd0, 24'd70);
    do_start(24'd69);
    do_step();
    chk(evt_o[0] == 1'b0, "R6 unrouted pulse", evt_o[0], 0);
    chk(flag_o[0] == 1'b1, "R7 flag set when unrouted", flag_o[0], 1);
    route_en_i = '1;

    // R7: sticky flag, irq mask, clear strobe
    @(negedge clk);
    chk(flag_o[0] == 1'b1, "R7 flag sticky", flag_o[0], 1);
    irq_en_i = 4'b0010;
    #1 chk(irq_o == 1'b0, "R7 irq masked", irq_o, 0);
    irq_en_i = 4'b0001;
    #1 chk(irq_o == 1'b1, "R7 irq enabled", irq_o, 1);
    do_fclr(4'b0001);
    chk(flag_o[0] == 1'b0 && irq_o == 1'b0, "R7 flag cleared", {flag_o[0], irq_o}, 0);
    irq_en_i = '0;

    // R8: unimplemented channel 3
    do_write(2'd3, 24'd81);
    do_start(24'd80);
    do_step();
    chk(evt_o[3] == 1'b0, "R8 absent channel pulse", evt_o[3], 0);
    chk(flag_o[3] == 1'b0, "R8 absent channel flag", flag_o[3], 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule